// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block turns a pair of quadrature signals into a 16-bit position count. The two channels are assumed to be synchronized to the system clock and already filtered. Each clock, every channel is compared with its own registered previous level. A change in level is an edge, and an edge can produce one step of the counter. The level of the other channel sets the direction of that step.

A 2-bit mode selects the counting resolution. The counter can step on channel 2 edges only, on channel 1 edges only, or on the edges of both channels. Counting also needs the enable input. The counter wraps at a programmable reload value in both directions. The direction output always shows the direction of the most recent step, as the hardware derived it.

Top module: `quad_enc_counter`

## Requirements
- R1: While reset is asserted and after it is released with no edges, `cnt_o` is 0 and `dir_o` is 0 (up). The edge history also resets to 0.
- R2: When `mode_i` = 2'b01, only edges of `ch2_i` step the counter. The step is up when the new `ch2_i` level equals `ch1_i`, and down otherwise.
- R3: When `mode_i` = 2'b10, only edges of `ch1_i` step the counter. The step is up when the new `ch1_i` level differs from `ch2_i`, and down otherwise.
- R4: When `mode_i` = 2'b11, an edge on either channel steps the counter, using the direction rule of that channel from R2 or R3.
- R5: When `mode_i` = 2'b11 and both channels change in the same cycle, there is no step and `dir_o` holds.
- R6: A step up from a count equal to `arr_i` gives 0. Any other step up adds 1.
- R7: A step down from 0 gives `arr_i`. Any other step down subtracts 1.
- R8: When `en_i` is low or `mode_i` = 2'b00, `cnt_o` and `dir_o` hold. The edge history keeps tracking the inputs, so enabling later does not replay an old edge.
- R9: `dir_o` is 1 for a down step and 0 for an up step. It changes only when a step occurs.
- R10: A step caused by the input levels sampled at one clock edge appears on `cnt_o` and `dir_o` just after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter enable |
| mode_i | input | 2 | 00 off, 01 channel 2 edges, 10 channel 1 edges, 11 both |
| ch1_i | input | 1 | Synchronized channel 1 level |
| ch2_i | input | 1 | Synchronized channel 2 level |
| arr_i | input | 16 | Reload (wrap) value |
| cnt_o | output | 16 | Counter value |
| dir_o | output | 1 | Direction of last step, 1 = down |

## Verification
The assertions assume three things about the inputs:
- The channels hold low while reset is asserted, so that the edge history the checker keeps starts out equal to the design's history.
- Every input changes only between clock edges.
- `arr_i` may change at any time. For that reason, the wrap check compares against the value `arr_i` had at the sampling edge.

The bench drives all inputs on the falling edge and keeps both channels low through reset. Except in the test that checks simultaneous edges on purpose, it moves one channel at a time, as a real encoder does.

// File: rtl/quad_enc_pkg.sv
package quad_enc_pkg;
  typedef enum logic [1:0] {
    ENC_OFF  = 2'b00,
    ENC_CH2  = 2'b01,
    ENC_CH1  = 2'b10,
    ENC_BOTH = 2'b11
  } enc_mode_e;

  typedef struct packed {
    logic step;
    logic up;
  } step_t;
endpackage

// File: rtl/quad_edge_det.sv
module quad_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign edge_o = lvl_i ^ prev_q;
endmodule

// File: rtl/quad_step_dec.sv
module quad_step_dec
  import quad_enc_pkg::*;
(
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] lvl_i,   // [0] ch1, [1] ch2
  input  logic [1:0] edge_i,
  output step_t      step_o
);
  logic up1, up2;

  assign up1 = lvl_i[0] ^ lvl_i[1];
  assign up2 = ~(lvl_i[0] ^ lvl_i[1]);

  always_comb begin
    step_o = '0;
    if (en_i) begin
      unique case (enc_mode_e'(mode_i))
        ENC_CH2:  step_o = '{step: edge_i[1], up: up2};
        ENC_CH1:  step_o = '{step: edge_i[0], up: up1};
        ENC_BOTH: begin
          // simultaneous edges are not a legal quadrature transition
          if (edge_i == 2'b01)      step_o = '{step: 1'b1, up: up1};
          else if (edge_i == 2'b10) step_o = '{step: 1'b1, up: up2};
        end
        default:  step_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/quad_wrap_cnt.sv
module quad_wrap_cnt
  import quad_enc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  step_t            step_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q;

  always_comb begin
    cnt_d = cnt_q;
    if (step_i.step) begin
      if (step_i.up) cnt_d = (cnt_q == arr_i) ? '0 : cnt_q + CNT_W'(1);
      else           cnt_d = (cnt_q == '0) ? arr_i : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (step_i.step) dir_q <= ~step_i.up;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/quad_enc_counter.sv
module quad_enc_counter
  import quad_enc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             ch1_i,
  input  logic             ch2_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o
);
  localparam int unsigned N_CH = 2;

  logic [N_CH-1:0] lvl, edg;
  step_t           step;

  assign lvl = {ch2_i, ch1_i};

  for (genvar g = 0; g < N_CH; g++) begin : g_edge
    quad_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl[g]),
      .edge_o (edg[g])
    );
  end

  quad_step_dec u_dec (
    .en_i   (en_i),
    .mode_i (mode_i),
    .lvl_i  (lvl),
    .edge_i (edg),
    .step_o (step)
  );

  quad_wrap_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .arr_i  (arr_i),
    .cnt_o  (cnt_o),
    .dir_o  (dir_o)
  );
endmodule

// File: rtl/quad_enc_counter_chk.sv
module quad_enc_counter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       mode_i,
  input logic             ch1_i,
  input logic             ch2_i,
  input logic [CNT_W-1:0] arr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             dir_o
);
  logic h1_q, h2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h1_q <= 1'b0;
      h2_q <= 1'b0;
    end else begin
      h1_q <= ch1_i;
      h2_q <= ch2_i;
    end
  end

  always_comb begin
    if (!rst_ni) assert_reset_state_R1: assert (cnt_o == '0 && dir_o == 1'b0);
  end

  assert_mode_ch2_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && ch2_i == h2_q) |=> $stable(cnt_o));

  assert_mode_ch2_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == 2'b01 && ch2_i != h2_q) |=> (dir_o == ($past(ch2_i) != $past(ch1_i))));

  assert_mode_ch1_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && ch1_i == h1_q) |=> $stable(cnt_o));

  assert_mode_ch1_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == 2'b10 && ch1_i != h1_q) |=> (dir_o == ($past(ch1_i) == $past(ch2_i))));

  assert_both_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == 2'b11 && ((ch1_i != h1_q) != (ch2_i != h2_q)) && arr_i != '0)
    |=> !$stable(cnt_o));

  assert_dual_edge_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && ch1_i != h1_q && ch2_i != h2_q) |=> ($stable(cnt_o) && $stable(dir_o)));

  // R6 R7: any count change is one step or a wrap
  assert_step_or_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_o) |-> (cnt_o == $past(cnt_o) + CNT_W'(1) || cnt_o == $past(cnt_o) - CNT_W'(1)
                         || cnt_o == '0 || cnt_o == $past(arr_i)));

  assert_down_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && en_i && mode_i == 2'b10 && ch1_i != h1_q && ch1_i == ch2_i)
    |=> cnt_o == $past(arr_i));

  assert_hold_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || mode_i == 2'b00) |=> ($stable(cnt_o) && $stable(dir_o)));

  assert_dir_only_on_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch1_i == h1_q && ch2_i == h2_q) |=> ($stable(dir_o) && $stable(cnt_o)));
endmodule

bind quad_enc_counter quad_enc_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_quad_enc_counter.sv
module tb_quad_enc_counter;
  localparam int unsigned CNT_W  = 16;
  localparam time         CLK_PER = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [1:0]       mode = 2'b00;
  logic             c1 = 1'b0, c2 = 1'b0;
  logic [CNT_W-1:0] arr = 16'd1000;
  logic [CNT_W-1:0] cnt;
  logic             dir;

  int n_chk = 0, n_bad = 0;
  logic [CNT_W-1:0] e_cnt = '0;
  logic             e_dir = 1'b0;
  logic             p1 = 1'b0, p2 = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  quad_enc_counter #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .ch1_i(c1), .ch2_i(c2), .arr_i(arr), .cnt_o(cnt), .dir_o(dir)
  );

  task automatic check(input string req);
    n_chk++;
    if (cnt !== e_cnt || dir !== e_dir) begin
      n_bad++;
      $display("FAIL %s: cnt=%0d dir=%0b expected cnt=%0d dir=%0b", req, cnt, dir, e_cnt, e_dir);
    end
  endtask

  // apply new levels at the falling edge, model per requirements, sample at next falling edge
  task automatic drv(input logic n1, input logic n2, input string req);
    logic e1, e2, stp, up;
    e1 = (n1 != p1); e2 = (n2 != p2); stp = 1'b0; up = 1'b0;
    if (en) begin
      case (mode)
        2'b01: begin stp = e2; up = (n2 == n1); end
        2'b10: begin stp = e1; up = (n1 != n2); end
        2'b11: if (e1 ^ e2) begin stp = 1'b1; up = e1 ? (n1 != n2) : (n2 == n1); end
        default: ;
      endcase
    end
    if (stp) begin
      e_dir = ~up;
      if (up) e_cnt = (e_cnt == arr) ? '0 : e_cnt + CNT_W'(1);
      else    e_cnt = (e_cnt == '0) ? arr : e_cnt - CNT_W'(1);
    end
    p1 = n1; p2 = n2;
    c1 = n1; c2 = n2;
    @(negedge clk);
    check(req);
  endtask

  task automatic t_reset;
    check("R1 reset");
    drv(1'b0, 1'b0, "R1 idle after reset");
  endtask

  task automatic t_both_fwd_rev;
    en = 1'b1; mode = 2'b11;
    drv(1, 0, "R4 fwd ch1 rise");
    drv(1, 1, "R4 fwd ch2 rise");
    drv(0, 1, "R4 fwd ch1 fall");
    drv(0, 0, "R10 R4 fwd ch2 fall");
    drv(0, 1, "R4 R9 rev ch2 rise");
    drv(1, 1, "R4 rev ch1 rise");
    drv(1, 0, "R4 rev ch2 fall");
    drv(0, 0, "R4 rev ch1 fall");
  endtask

  task automatic t_wrap;
    drv(0, 1, "R7 down wrap to reload");
    drv(0, 0, "R6 up wrap to zero");
    arr = 16'd3;
    drv(1, 0, "R6 small reload step");
    drv(1, 1, "R6 small reload step");
    drv(0, 1, "R6 small reload step");
    drv(0, 0, "R6 wrap at reload 3");
    arr = 16'd1000;
  endtask

  task automatic t_mode_ch2;
    mode = 2'b01;
    drv(1, 0, "R2 ch1 edge ignored");
    drv(1, 1, "R2 ch2 rise equal up");
    drv(0, 1, "R2 ch1 edge ignored");
    drv(0, 0, "R2 ch2 fall equal up");
    drv(1, 0, "R2 ch1 edge ignored");
    drv(1, 1, "R2 ch2 rise");
    drv(0, 1, "R2 ignored");
    drv(0, 0, "R2 ch2 fall");
    drv(0, 1, "R2 ch2 rise differ down");
  endtask

  task automatic t_mode_ch1;
    mode = 2'b10;
    drv(0, 0, "R3 ch2 edge ignored");
    drv(1, 0, "R3 ch1 rise differ up");
    drv(1, 1, "R3 ch2 edge ignored");
    drv(0, 1, "R3 ch1 fall differ up");
    drv(1, 1, "R3 ch1 rise equal down");
  endtask

  task automatic t_disabled;
    en = 1'b0;
    drv(0, 1, "R8 disabled ch1 edge");
    drv(0, 0, "R8 disabled ch2 edge");
    en = 1'b1;
    drv(0, 0, "R8 enable no replay");
    mode = 2'b00;
    drv(1, 0, "R8 mode off ch1 edge");
    drv(1, 1, "R8 mode off ch2 edge");
  endtask

  task automatic t_dual_edge;
    mode = 2'b11;
    drv(0, 0, "R5 dual edge ignored");
    drv(1, 1, "R5 dual edge ignored");
    drv(1, 0, "R5 single edge after dual");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_both_fwd_rev();
    t_wrap();
    t_mode_ch2();
    t_mode_ch1();
    t_disabled();
    t_dual_edge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: cnt=%0d expected run end", cnt);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule